// File: doc/BRIEF.md
# Paced Dual Pulse Output Spreader

This block drives two pulse pins, W and V. A compute engine writes the levels for both pins in a short burst at the start of each processing pass. The block queues those levels and plays them back one update at a time, at evenly spaced instants across the multiplexer frame. An 8-bit interval setting fixes the spacing, in steps of four clock cycles. The same spacing sets the delay from the frame-start strobe to the first update.

When the interval setting is zero, the queue is bypassed and each written level goes straight to the pins. When pacing is active, a width limiter can force a pin back to its inactive level. The limit is a whole number of update periods, set by a second 8-bit value. A polarity bit chooses between active-low pins (the default) and active-high pins.

The write side uses valid/ready. `wr_ready` is high when the queue has room, when pacing is off, or during a frame-start cycle. The source does not stall. A write presented while `wr_ready` is low is discarded.

Top module: `pulse_spreader`

## Requirements
- R1: After reset both internal levels are inactive (pins high when `invert`=0), the queue is empty and `wr_ready` is 1.
- R2: With `interval`=0, a write with `wr_valid`=1 sets the W and V levels to `wr_w` and `wr_v` at the next clock edge, and nothing is queued.
- R3: With `interval`=N≠0 and TI=4·N cycles, the first queued level is applied TI clock edges after the edge that samples `frame_start`. Later levels follow every TI edges after that.
- R4: The queue is first-in first-out and holds 8 entries of {W,V}. While it is full, `wr_ready` is 0 and any write is discarded. `wr_ready` returns to 1 after a pop.
- R5: An update instant that finds the queue empty leaves both levels unchanged.
- R6: `frame_start` empties the queue, so entries left over from the previous frame are never output. A write in the same cycle as `frame_start` is kept as the first entry of the new frame.
- R7: With pacing active and `maxwidth`=M≠255, a level that has just become active is forced inactive after (2·M+1)·TI clock cycles.
- R8: Width limiting is off when `maxwidth`=255 or `interval`=0, so an active level stays active until a new level is loaded.
- R9: With `invert`=0 a pin is low when its level is active. With `invert`=1 a pin is high when its level is active. The pins follow `invert` at once.
- R10: Each `frame_start` restarts the interval countdown from the full TI, whatever phase the countdown was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Start-of-frame strobe; clears the queue and restarts pacing |
| wr_valid | input | 1 | Level write valid |
| wr_ready | output | 1 | Write accepted (queue has room, bypass, or frame start) |
| wr_w | input | 1 | W level for this update (1 = active) |
| wr_v | input | 1 | V level for this update (1 = active) |
| interval | input | 8 | Update spacing in units of 4 cycles; 0 selects bypass |
| maxwidth | input | 8 | Width limit in units of 2·TI plus one TI; 255 disables |
| invert | input | 1 | 1 makes the pins active-high |
| w_pulse | output | 1 | W pulse pin |
| v_pulse | output | 1 | V pulse pin |

## Verification
Pacing is checked with a three-entry burst of distinct {W,V} pairs. Each pin is sampled one cycle before each expected update instant and again on it. This separates a correct delay and spacing from an off-by-one counter or a swapped channel.

A ten-write burst into a slow pace fills the queue and then drains it. The two extra writes carry a value that no stored entry ends with, so a lost entry, a reordering or an accepted overflow each shows up at a different update.

A second frame strobe is sent while the countdown is mid-way, with stale entries still queued. This shows whether the queue was cleared and the countdown restarted.

Width-limit runs with M=0, M=1 and M=255 compare pulse lengths of 4 cycles, 12 cycles and unlimited. Bypass writes are run under both polarities.

// File: rtl/pulse_spreader_pkg.sv
package pulse_spreader_pkg;
  // One update: W and V levels, 1 = active.
  typedef struct packed {
    logic w;
    logic v;
  } pls_pair_t;
endpackage

// File: rtl/ps_queue.sv
module ps_queue
  import pulse_spreader_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            push,
  input  logic            pop,
  input  pls_pair_t       din,
  output pls_pair_t       dout,
  output logic            full,
  output logic            empty,
  output logic [CW-1:0]   count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pls_pair_t      mem [DEPTH];
  logic [AW-1:0]  rd_ptr, wr_ptr, wr_addr;
  logic           push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && (clr || !full);
  assign pop_ok  = pop && !empty && !clr;
  assign wr_addr = clr ? '0 : wr_ptr;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      wr_ptr <= push_ok ? AW'(1) : '0;
      count  <= push_ok ? CW'(1) : '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ps_pacer.sv
module ps_pacer #(
  parameter int IV_W     = 8,
  parameter int PRESCALE = 4,
  parameter int TW       = IV_W + $clog2(PRESCALE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic [IV_W-1:0] interval,
  output logic            tick
);
  localparam int SH = $clog2(PRESCALE);

  logic [TW-1:0] period;
  logic [TW-1:0] cnt;
  logic          run;
  logic          paced;

  assign paced  = (interval != '0);
  assign period = TW'(interval) << SH;
  assign tick   = run && paced && !frame_start && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (frame_start) begin
      run <= paced;
      cnt <= period - 1'b1;
    end else if (run) begin
      if (!paced)          run <= 1'b0;
      else if (cnt == '0)  cnt <= period - 1'b1;
      else                 cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ps_lane.sv
module ps_lane #(
  parameter int LW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          val,
  input  logic          lim_en,
  input  logic [LW-1:0] lim,
  output logic          lvl
);
  logic [LW-1:0] cnt;
  logic          force_off;
  logic          lvl_nxt;
  logic          entering;

  assign force_off = lvl && lim_en && (cnt >= lim - 1'b1);
  assign lvl_nxt   = force_off ? 1'b0 : (load ? val : lvl);
  assign entering  = lvl_nxt && !lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl <= 1'b0;
      cnt <= '0;
    end else begin
      lvl <= lvl_nxt;
      if (!lvl_nxt || entering)  cnt <= '0;
      else if (cnt != '1)        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pulse_spreader.sv
module pulse_spreader
  import pulse_spreader_pkg::*;
#(
  parameter int IV_W     = 8,
  parameter int MW_W     = 8,
  parameter int DEPTH    = 8,
  parameter int PRESCALE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic            wr_w,
  input  logic            wr_v,
  input  logic [IV_W-1:0] interval,
  input  logic [MW_W-1:0] maxwidth,
  input  logic            invert,
  output logic            w_pulse,
  output logic            v_pulse
);
  localparam int SH = $clog2(PRESCALE);
  localparam int TW = IV_W + SH;
  localparam int LW = MW_W + 1 + TW;
  localparam int CW = $clog2(DEPTH + 1);

  logic            bypass;
  logic            tick;
  logic            q_full, q_empty, q_pop;
  logic [CW-1:0]   q_count;
  pls_pair_t       q_out, wr_pair, ld_pair;
  logic            ld;
  logic [TW-1:0]   period;
  logic [LW-1:0]   limit;
  logic            lim_en;
  logic [1:0]      lvl;
  logic            w_lvl;

  assign bypass   = (interval == '0);
  assign wr_pair  = '{w: wr_w, v: wr_v};
  assign wr_ready = bypass || frame_start || !q_full;
  assign q_pop    = tick && !q_empty;
  assign period   = TW'(interval) << SH;
  assign limit    = LW'({maxwidth, 1'b1}) * LW'(period);
  assign lim_en   = !bypass && (maxwidth != '1);
  assign ld       = bypass ? wr_valid : q_pop;
  assign ld_pair  = bypass ? wr_pair : q_out;

  ps_pacer #(.IV_W(IV_W), .PRESCALE(PRESCALE), .TW(TW)) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .interval   (interval),
    .tick       (tick)
  );

  ps_queue #(.DEPTH(DEPTH), .CW(CW)) u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (frame_start),
    .push (wr_valid && !bypass),
    .pop  (q_pop),
    .din  (wr_pair),
    .dout (q_out),
    .full (q_full),
    .empty(q_empty),
    .count(q_count)
  );

  // lvl[1] = W lane, lvl[0] = V lane
  for (genvar g = 0; g < 2; g++) begin : g_lane
    ps_lane #(.LW(LW)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ld),
      .val   (g == 1 ? ld_pair.w : ld_pair.v),
      .lim_en(lim_en),
      .lim   (limit),
      .lvl   (lvl[g])
    );
  end

  assign w_lvl   = lvl[1];
  assign w_pulse = invert ? lvl[1] : !lvl[1];
  assign v_pulse = invert ? lvl[0] : !lvl[0];
endmodule

// File: rtl/pulse_spreader_chk.sv
module pulse_spreader_chk #(
  parameter int IV_W = 8,
  parameter int CW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frame_start,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            wr_w,
  input logic [IV_W-1:0] interval,
  input logic            tick,
  input logic [CW-1:0]   q_count,
  input logic            w_lvl
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!w_lvl && q_count == '0)); // R1

  AST_BYPASS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (interval == '0 && wr_valid) |=> (w_lvl == $past(wr_w))); // R2

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (interval != '0 && wr_valid && !wr_ready && !tick) |=> (q_count == $past(q_count))); // R4

  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && q_count == '0) |=> (w_lvl == $past(w_lvl) || !w_lvl)); // R5

  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (q_count <= CW'(1))); // R6
endmodule

bind pulse_spreader pulse_spreader_chk #(.IV_W(IV_W), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_start(frame_start),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_w       (wr_w),
  .interval   (interval),
  .tick       (tick),
  .q_count    (q_count),
  .w_lvl      (w_lvl)
);

// File: tb/pulse_spreader_bench.sv
`timescale 1ns/1ps
module pulse_spreader_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_w = 1'b0, wr_v = 1'b0;
  logic [7:0] interval = 8'd0;
  logic [7:0] maxwidth = 8'd255;
  logic       invert = 1'b0;
  logic       w_pulse, v_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_spreader u_pulse_spreader (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_w(wr_w), .wr_v(wr_v),
    .interval(interval), .maxwidth(maxwidth), .invert(invert),
    .w_pulse(w_pulse), .v_pulse(v_pulse)
  );

  function automatic logic [1:0] pins_for(input logic [1:0] act, input logic inv);
    return inv ? act : ~act;
  endfunction

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pins_are(input string req, input logic [1:0] act_lvl);
    chk(req, {w_pulse, v_pulse}, pins_for(act_lvl, invert));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wr(input logic w, input logic v);
    wr_valid = 1'b1; wr_w = w; wr_v = v;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic clear_levels();
    logic [7:0] keep;
    keep = interval;
    interval = 8'd0;
    wr(1'b0, 1'b0);
    interval = keep;
  endtask

  task automatic t_reset();
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    pins_are("R1 idle pins", 2'b00);
    chk("R1 ready", {1'b0, wr_ready}, 2'b01);
  endtask

  task automatic t_bypass();
    interval = 8'd0; maxwidth = 8'd0;
    wr(1'b1, 1'b0);
    pins_are("R2 bypass write", 2'b10);
    cyc(50);
    pins_are("R8 no limit in bypass", 2'b10);
    wr(1'b0, 1'b1);
    pins_are("R2 bypass second write", 2'b01);
  endtask

  task automatic t_polarity();
    invert = 1'b1;
    #1;
    chk("R9 inverted pins", {w_pulse, v_pulse}, 2'b01);
    wr(1'b1, 1'b1);
    chk("R9 inverted both active", {w_pulse, v_pulse}, 2'b11);
    invert = 1'b0;
    #1;
    chk("R9 normal both active", {w_pulse, v_pulse}, 2'b00);
    wr(1'b0, 1'b0);
    pins_are("R9 idle", 2'b00);
  endtask

  task automatic t_spacing();
    interval = 8'd2; maxwidth = 8'd255;
    frame();
    wr(1'b1, 1'b0); wr(1'b0, 1'b1); wr(1'b1, 1'b1);
    cyc(4);  pins_are("R3 before first update", 2'b00);
    cyc(1);  pins_are("R3 first update at TI", 2'b10);
    cyc(7);  pins_are("R3 held between updates", 2'b10);
    cyc(1);  pins_are("R3 second update", 2'b01);
    cyc(8);  pins_are("R3 third update", 2'b11);
    clear_levels();
  endtask

  task automatic t_full();
    interval = 8'd4; maxwidth = 8'd255;
    frame();
    for (int k = 1; k <= 8; k++) begin
      logic [3:0] kk;
      kk = 4'(k);
      wr(kk[0], kk[1]);
    end
    chk("R4 ready low when full", {1'b0, wr_ready}, 2'b00);
    wr(1'b1, 1'b1); wr(1'b1, 1'b1);
    cyc(6);
    for (int j = 1; j <= 9; j++) begin
      logic [3:0] jj;
      jj = (j <= 8) ? 4'(j) : 4'd8;
      if (j <= 8) pins_are("R4 fifo order", {jj[0], jj[1]});
      else        pins_are("R5 empty update holds", {jj[0], jj[1]});
      if (j == 1) chk("R4 ready after pop", {1'b0, wr_ready}, 2'b01);
      if (j < 9) cyc(16);
    end
  endtask

  task automatic t_restart();
    interval = 8'd4; maxwidth = 8'd255;
    clear_levels();
    frame();
    wr(1'b1, 1'b1); wr(1'b1, 1'b1); wr(1'b1, 1'b1);
    cyc(2);
    frame();
    wr(1'b1, 1'b0);
    cyc(14); pins_are("R10 no early update", 2'b00);
    cyc(1);  pins_are("R6 stale entries dropped", 2'b10);
    cyc(16); pins_are("R5 empty after one entry", 2'b10);
  endtask

  task automatic t_same_cycle();
    clear_levels();
    frame_start = 1'b1; wr_valid = 1'b1; wr_w = 1'b0; wr_v = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; wr_valid = 1'b0;
    cyc(15); pins_are("R6 before update", 2'b00);
    cyc(1);  pins_are("R6 write with frame kept", 2'b01);
  endtask

  task automatic t_width();
    interval = 8'd1; maxwidth = 8'd0;
    clear_levels();
    frame(); wr(1'b1, 1'b1);
    cyc(6); pins_are("R7 active within limit M0", 2'b11);
    cyc(1); pins_are("R7 forced off after 4", 2'b00);
    maxwidth = 8'd1;
    frame(); wr(1'b1, 1'b1);
    cyc(14); pins_are("R7 active within limit M1", 2'b11);
    cyc(1);  pins_are("R7 forced off after 12", 2'b00);
    maxwidth = 8'd255;
    frame(); wr(1'b1, 1'b1);
    cyc(40); pins_are("R8 no limit at 255", 2'b11);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_polarity();
    t_spacing();
    t_full();
    t_restart();
    t_same_cycle();
    t_width();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule